// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the main control unit of a small single-cycle 32-bit RISC core that runs a 22-instruction subset. It is purely combinational. It takes the 6-bit primary opcode and the 6-bit function field of the current instruction and produces the 17 control bits that steer the datapath for that cycle. These bits cover register write, destination and write-back selection, ALU operand source and operation class, data-memory read and write strobes, the branch condition and the next-PC source.

The decode has two levels. Each field first passes through its own one-hot 6-to-64 decoder. A table held in the package turns pairs of those lines into 22 per-instruction lines. The per-instruction lines are then ORed into shared class terms (arithmetic, logic, immediate), and the class terms are ORed into the final controls. To add an instruction, a designer adds one table entry and extends the relevant OR terms. The rest of the decoder stays as it is.

Top module: `ctl_decoder`

## Requirements
- R1: Exactly 22 encodings are recognised. With opcode 0, the function codes are add=32, sub=34, slt=42, and=36, or=37, xor=38, nor=39, jr=8 and syscall=12. The other recognised opcodes are bltz=1, j=2, jal=3, beq=4, bne=5, addi=8, slti=10, andi=12, ori=13, xori=14, lui=15, lw=35 and sw=43. For an opcode other than 0, the function field is ignored.
- R2: `reg_wr_o` is 1 exactly for lui, add, sub, slt, and, or, xor, nor, addi, slti, andi, ori, xori, lw and jal.
- R3: `reg_dst_o` is 1 (rd) for the seven register-register ALU operations and 2 (link register 31) for jal. It is 0 (rt) otherwise.
- R4: `alu_src_o` is 1 (sign-extended immediate) for lui, addi, slti, andi, ori, xori, lw and sw. It is 0 (rt operand) otherwise.
- R5: `add_sub_o` is 1 (subtract) for sub, slt and slti, and 0 otherwise.
- R6: `logic_fn_o` is 1 for or and ori, 2 for xor and xori, and 3 for nor. It is 0 otherwise, which includes and and andi.
- R7: `fn_class_o` has four values. It is 1 (set-less-than) for slt and slti. It is 2 (add/sub) for add, sub, addi, lw and sw. It is 3 (logic) for and, or, xor, nor, andi, ori and xori. It is 0 otherwise, which includes lui.
- R8: `mem_rd_o` is 1 only for lw, and `mem_wr_o` is 1 only for sw.
- R9: `reg_in_src_o` is 2 (incremented PC) for jal. It is 1 (ALU result) for lui and for every arithmetic and logic instruction. It is 0 (data memory) otherwise, which includes lw.
- R10: `br_type_o` is 1 for beq, 2 for bne and 3 for bltz. It is 0 (no branch) otherwise.
- R11: `pc_src_o` is 1 (jump target) for j and jal, 2 (register) for jr and 3 (system entry constant) for syscall. It is 0 (incremented PC or branch) otherwise.
- R12: An unrecognised opcode/function pair drives all 17 control bits to 0. This means no register write, no memory access and a sequential PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Primary opcode field |
| fn_i | input | 6 | Function field (used when opcode is 0) |
| reg_wr_o | output | 1 | Register file write enable |
| reg_dst_o | output | 2 | Destination register select |
| alu_src_o | output | 1 | ALU second operand select |
| add_sub_o | output | 1 | Adder subtract control |
| logic_fn_o | output | 2 | Logic unit function |
| fn_class_o | output | 2 | ALU result class select |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| reg_in_src_o | output | 2 | Register write-back source |
| br_type_o | output | 2 | Branch condition type |
| pc_src_o | output | 2 | Next-PC source |

## Verification
The inline assertions are evaluated on every input change. They check that each field decoder is strictly one-hot and that at most one instruction line is active at a time. They also check the relations between the per-instruction lines and the controls: no write to both memory and the register file, lw write-back taken from memory, branches keeping the sequential PC source, and all-zero controls when no line is active. The exact value of each control field for each encoding, and whether the function field is truly ignored for non-zero opcodes, can only be shown by the bench. The bench sweeps all 4096 opcode/function pairs against values it derives independently.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int FIELD_W = 6;
  localparam int DEC_N   = 1 << FIELD_W;
  localparam int N_INSN  = 22;

  // per-instruction line indices
  localparam int I_ADD  = 0;
  localparam int I_SUB  = 1;
  localparam int I_SLT  = 2;
  localparam int I_AND  = 3;
  localparam int I_OR   = 4;
  localparam int I_XOR  = 5;
  localparam int I_NOR  = 6;
  localparam int I_JR   = 7;
  localparam int I_SYS  = 8;
  localparam int I_LUI  = 9;
  localparam int I_ADDI = 10;
  localparam int I_SLTI = 11;
  localparam int I_ANDI = 12;
  localparam int I_ORI  = 13;
  localparam int I_XORI = 14;
  localparam int I_LW   = 15;
  localparam int I_SW   = 16;
  localparam int I_J    = 17;
  localparam int I_JAL  = 18;
  localparam int I_BEQ  = 19;
  localparam int I_BNE  = 20;
  localparam int I_BLTZ = 21;

  localparam logic [FIELD_W-1:0] OP_REG = '0;

  // opcode assigned to each line; OP_REG means decoded through the function field
  function automatic logic [FIELD_W-1:0] insn_op(int idx);
    case (idx)
      I_LUI:   return FIELD_W'(15);
      I_ADDI:  return FIELD_W'(8);
      I_SLTI:  return FIELD_W'(10);
      I_ANDI:  return FIELD_W'(12);
      I_ORI:   return FIELD_W'(13);
      I_XORI:  return FIELD_W'(14);
      I_LW:    return FIELD_W'(35);
      I_SW:    return FIELD_W'(43);
      I_J:     return FIELD_W'(2);
      I_JAL:   return FIELD_W'(3);
      I_BEQ:   return FIELD_W'(4);
      I_BNE:   return FIELD_W'(5);
      I_BLTZ:  return FIELD_W'(1);
      default: return OP_REG;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] insn_fn(int idx);
    case (idx)
      I_ADD:   return FIELD_W'(32);
      I_SUB:   return FIELD_W'(34);
      I_SLT:   return FIELD_W'(42);
      I_AND:   return FIELD_W'(36);
      I_OR:    return FIELD_W'(37);
      I_XOR:   return FIELD_W'(38);
      I_NOR:   return FIELD_W'(39);
      I_JR:    return FIELD_W'(8);
      I_SYS:   return FIELD_W'(12);
      default: return '0;
    endcase
  endfunction

  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_e;
  typedef enum logic [1:0] {LF_AND = 2'd0, LF_OR = 2'd1, LF_XOR = 2'd2, LF_NOR = 2'd3} lfn_e;
  typedef enum logic [1:0] {FC_LUI = 2'd0, FC_SLT = 2'd1, FC_ARITH = 2'd2, FC_LOGIC = 2'd3} fcls_e;
  typedef enum logic [1:0] {WB_MEM = 2'd0, WB_ALU = 2'd1, WB_PC = 2'd2} wb_e;
  typedef enum logic [1:0] {BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2, BR_LTZ = 2'd3} br_e;
  typedef enum logic [1:0] {PC_SEQ = 2'd0, PC_JTA = 2'd1, PC_REG = 2'd2, PC_SYS = 2'd3} pcs_e;

  typedef struct packed {
    logic  reg_wr;
    dst_e  reg_dst;
    logic  alu_src;
    logic  add_sub;
    lfn_e  logic_fn;
    fcls_e fn_class;
    logic  mem_rd;
    logic  mem_wr;
    wb_e   reg_in_src;
    br_e   br_type;
    pcs_e  pc_src;
  } ctl_t;

endpackage

// File: rtl/ctl_field_dec.sv
module ctl_field_dec #(
  parameter int W = 6,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] val_i,
  output logic [N-1:0] hot_o
);

  for (genvar i = 0; i < N; i++) begin : g_hot
    assign hot_o[i] = (val_i == W'(i));
  end

  always_comb begin
    assert_field_onehot_R1: assert ($onehot(hot_o));
  end

endmodule

// File: rtl/ctl_insn_lines.sv
module ctl_insn_lines
  import ctl_pkg::*;
(
  input  logic [DEC_N-1:0]  op_hot_i,
  input  logic [DEC_N-1:0]  fn_hot_i,
  output logic [N_INSN-1:0] line_o
);

  for (genvar i = 0; i < N_INSN; i++) begin : g_line
    localparam logic [FIELD_W-1:0] OPC = insn_op(i);
    localparam logic [FIELD_W-1:0] FNC = insn_fn(i);
    if (OPC == OP_REG) begin : g_reg
      assign line_o[i] = op_hot_i[OP_REG] & fn_hot_i[FNC];
    end else begin : g_imm
      assign line_o[i] = op_hot_i[OPC];
    end
  end

  // not every decoder line maps to an instruction
  logic unused_hot;
  assign unused_hot = ^{op_hot_i, fn_hot_i};

  always_comb begin
    assert_single_line_R1: assert ($onehot0(line_o));
  end

endmodule

// File: rtl/ctl_class_or.sv
module ctl_class_or
  import ctl_pkg::*;
(
  input  logic [N_INSN-1:0] line_i,
  output ctl_t              ctl_o
);

  logic arith_c, logic_c, imm_c, rr_alu_c, slt_c, addsub_c;

  // class terms shared by several controls
  assign arith_c  = line_i[I_ADD] | line_i[I_SUB] | line_i[I_SLT] | line_i[I_ADDI] | line_i[I_SLTI];
  assign logic_c  = line_i[I_AND] | line_i[I_OR] | line_i[I_XOR] | line_i[I_NOR]
                  | line_i[I_ANDI] | line_i[I_ORI] | line_i[I_XORI];
  assign imm_c    = line_i[I_LUI] | line_i[I_ADDI] | line_i[I_SLTI]
                  | line_i[I_ANDI] | line_i[I_ORI] | line_i[I_XORI];
  assign rr_alu_c = line_i[I_ADD] | line_i[I_SUB] | line_i[I_SLT] | line_i[I_AND]
                  | line_i[I_OR] | line_i[I_XOR] | line_i[I_NOR];
  assign slt_c    = line_i[I_SLT] | line_i[I_SLTI];
  assign addsub_c = line_i[I_ADD] | line_i[I_SUB] | line_i[I_ADDI] | line_i[I_LW] | line_i[I_SW];

  always_comb begin
    ctl_o.reg_wr      = line_i[I_LUI] | arith_c | logic_c | line_i[I_LW] | line_i[I_JAL];
    ctl_o.reg_dst     = dst_e'({line_i[I_JAL], rr_alu_c});
    ctl_o.alu_src     = imm_c | line_i[I_LW] | line_i[I_SW];
    ctl_o.add_sub     = line_i[I_SUB] | slt_c;
    ctl_o.logic_fn    = lfn_e'({line_i[I_XOR] | line_i[I_XORI] | line_i[I_NOR],
                                line_i[I_OR] | line_i[I_ORI] | line_i[I_NOR]});
    ctl_o.fn_class    = fcls_e'({addsub_c | logic_c, slt_c | logic_c});
    ctl_o.mem_rd      = line_i[I_LW];
    ctl_o.mem_wr      = line_i[I_SW];
    ctl_o.reg_in_src  = wb_e'({line_i[I_JAL], line_i[I_LUI] | arith_c | logic_c});
    ctl_o.br_type     = br_e'({line_i[I_BNE] | line_i[I_BLTZ], line_i[I_BEQ] | line_i[I_BLTZ]});
    ctl_o.pc_src      = pcs_e'({line_i[I_JR] | line_i[I_SYS],
                                line_i[I_J] | line_i[I_JAL] | line_i[I_SYS]});
  end

  always_comb begin
    assert_no_dual_write_R8: assert (!(ctl_o.reg_wr && ctl_o.mem_wr));
    assert_load_wb_mem_R9: assert (!line_i[I_LW] || (ctl_o.reg_wr && ctl_o.reg_in_src == WB_MEM));
    assert_link_dest_R3: assert (!line_i[I_JAL] || (ctl_o.reg_dst == DST_LINK && ctl_o.pc_src == PC_JTA));
    assert_branch_seq_pc_R10: assert (ctl_o.br_type == BR_NONE || ctl_o.pc_src == PC_SEQ);
    assert_idle_zero_R12: assert ((|line_i) || ctl_o == '0);
  end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output logic       reg_wr_o,
  output logic [1:0] reg_dst_o,
  output logic       alu_src_o,
  output logic       add_sub_o,
  output logic [1:0] logic_fn_o,
  output logic [1:0] fn_class_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic [1:0] reg_in_src_o,
  output logic [1:0] br_type_o,
  output logic [1:0] pc_src_o
);

  logic [DEC_N-1:0]  op_hot, fn_hot;
  logic [N_INSN-1:0] line;
  ctl_t              ctl;

  ctl_field_dec #(.W(FIELD_W)) u_op_dec (.val_i(op_i), .hot_o(op_hot));
  ctl_field_dec #(.W(FIELD_W)) u_fn_dec (.val_i(fn_i), .hot_o(fn_hot));

  ctl_insn_lines u_lines (.op_hot_i(op_hot), .fn_hot_i(fn_hot), .line_o(line));

  ctl_class_or u_or (.line_i(line), .ctl_o(ctl));

  assign reg_wr_o     = ctl.reg_wr;
  assign reg_dst_o    = ctl.reg_dst;
  assign alu_src_o    = ctl.alu_src;
  assign add_sub_o    = ctl.add_sub;
  assign logic_fn_o   = ctl.logic_fn;
  assign fn_class_o   = ctl.fn_class;
  assign mem_rd_o     = ctl.mem_rd;
  assign mem_wr_o     = ctl.mem_wr;
  assign reg_in_src_o = ctl.reg_in_src;
  assign br_type_o    = ctl.br_type;
  assign pc_src_o     = ctl.pc_src;

  always_comb begin
    assert_store_no_wb_R2: assert (!mem_wr_o || !reg_wr_o);
    assert_rd_only_reg_op_R3: assert (reg_dst_o != 2'd1 || op_i == 6'd0);
    assert_mem_uses_imm_R4: assert (!(mem_rd_o || mem_wr_o) || alu_src_o);
  end

endmodule

// File: tb/sim_ctl_decoder.sv
module sim_ctl_decoder;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] op_i = '0, fn_i = '0;
  logic       reg_wr_o, alu_src_o, add_sub_o, mem_rd_o, mem_wr_o;
  logic [1:0] reg_dst_o, logic_fn_o, fn_class_o, reg_in_src_o, br_type_o, pc_src_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int nonzero = 0;

  always #4 clk = ~clk;  // 125 MHz

  ctl_decoder u0 (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired got %0d cycles expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s op=%0d fn=%0d got %0d expected %0d", tag, op_i, fn_i, got, exp);
    end
  endtask

  // expected fields: rw dst asrc as lf fc dr dw wb bt ps
  typedef struct {
    int rw, dst, asrc, sub, lf, fc, dr, dw, wb, bt, ps;
  } exp_t;

  function automatic exp_t model(int op, int fn);
    exp_t e = '{default: 0};
    bit alu = 0;
    if (op == 0) begin
      case (fn)
        32: begin alu = 1; e.dst = 1; e.fc = 2; end
        34: begin alu = 1; e.dst = 1; e.fc = 2; e.sub = 1; end
        42: begin alu = 1; e.dst = 1; e.fc = 1; e.sub = 1; end
        36: begin alu = 1; e.dst = 1; e.fc = 3; e.lf = 0; end
        37: begin alu = 1; e.dst = 1; e.fc = 3; e.lf = 1; end
        38: begin alu = 1; e.dst = 1; e.fc = 3; e.lf = 2; end
        39: begin alu = 1; e.dst = 1; e.fc = 3; e.lf = 3; end
        8:  e.ps = 2;
        12: e.ps = 3;
        default: ;
      endcase
    end else begin
      case (op)
        1:  e.bt = 3;
        2:  e.ps = 1;
        3:  begin e.rw = 1; e.dst = 2; e.wb = 2; e.ps = 1; end
        4:  e.bt = 1;
        5:  e.bt = 2;
        8:  begin alu = 1; e.asrc = 1; e.fc = 2; end
        10: begin alu = 1; e.asrc = 1; e.fc = 1; e.sub = 1; end
        12: begin alu = 1; e.asrc = 1; e.fc = 3; e.lf = 0; end
        13: begin alu = 1; e.asrc = 1; e.fc = 3; e.lf = 1; end
        14: begin alu = 1; e.asrc = 1; e.fc = 3; e.lf = 2; end
        15: begin alu = 1; e.asrc = 1; e.fc = 0; end
        35: begin e.rw = 1; e.asrc = 1; e.fc = 2; e.dr = 1; end
        43: begin e.asrc = 1; e.fc = 2; e.dw = 1; end
        default: ;
      endcase
    end
    if (alu) begin e.rw = 1; e.wb = 1; end
    return e;
  endfunction

  function automatic bit known(int op, int fn);
    if (op == 0) return (fn inside {8, 12, 32, 34, 36, 37, 38, 39, 42});
    return (op inside {1, 2, 3, 4, 5, 8, 10, 12, 13, 14, 15, 35, 43});
  endfunction

  function automatic logic [16:0] packed_out();
    return {reg_wr_o, reg_dst_o, alu_src_o, add_sub_o, logic_fn_o, fn_class_o,
            mem_rd_o, mem_wr_o, reg_in_src_o, br_type_o, pc_src_o};
  endfunction

  initial begin
    logic [16:0] ref_fn0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // start-up state: op 0 fn 0 is not a recognised encoding
    @(negedge clk);
    check("R12 start-up all-zero", int'(packed_out()), 0);

    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        exp_t e;
        @(posedge clk);
        #1;
        op_i = 6'(op);
        fn_i = 6'(fn);
        @(negedge clk);
        e = model(op, fn);
        check("R2 reg_wr",      int'(reg_wr_o),     e.rw);
        check("R3 reg_dst",     int'(reg_dst_o),    e.dst);
        check("R4 alu_src",     int'(alu_src_o),    e.asrc);
        check("R5 add_sub",     int'(add_sub_o),    e.sub);
        check("R6 logic_fn",    int'(logic_fn_o),   e.lf);
        check("R7 fn_class",    int'(fn_class_o),   e.fc);
        check("R8 mem_rd",      int'(mem_rd_o),     e.dr);
        check("R8 mem_wr",      int'(mem_wr_o),     e.dw);
        check("R9 reg_in_src",  int'(reg_in_src_o), e.wb);
        check("R10 br_type",    int'(br_type_o),    e.bt);
        check("R11 pc_src",     int'(pc_src_o),     e.ps);
        if (!known(op, fn))
          check("R12 unrecognised all-zero", int'(packed_out()), 0);
        if (packed_out() != '0) nonzero++;
        // R1: function field ignored for non-zero opcodes
        if (fn == 0) ref_fn0 = packed_out();
        else if (op != 0) check("R1 fn ignored", int'(packed_out()), int'(ref_fn0));
      end
    end

    // R1: 9 function-coded + 13 opcodes x 64 function values
    check("R1 recognised count", nonzero, 9 + 13 * 64);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule